// File: doc/BRIEF.md
# Expansion Bus Card Responder

This block sits on an expansion card attached to an asynchronous, 8-bit-data bus of the 68000 family. It watches the address, the active-low address and data strobes, and the read/write line. When a cycle targets the card, it raises an active-high line that silences every device on the main board for that cycle. Because that same line also stops the main board from acknowledging, the block must finish the cycle itself by pulling the active-low transfer acknowledge. No bus-error timer exists on this bus, so a matched cycle that is never acknowledged would stall the processor forever.

A card is selected by a four-bit field of the address, bits 17 down to 14, compared against a build-time card number. A small byte-wide register file, indexed by the lowest address bits, stands in for the card's storage. A wait count presented on an input sets how many clocks pass between the card taking the cycle and the acknowledge. Both strobes cross into the block's clock domain through a two-stage synchronizer before any decision is made.

Top module: `exb_responder`

## Requirements
- R1: After synchronous reset the disable line is low, the acknowledge enable is low with the acknowledge level high, and the data enable is low.
- R2: A cycle is taken only when address bits 17..14 equal the parameter CARD_SEL while both strobes are low; the disable line then rises on the third rising edge after the strobes fall. A cycle with any other value in bits 17..14 leaves disable, acknowledge enable and data enable low for as long as the strobes stay low.
- R3: Acknowledge is pulled low (enable high, level low) exactly max(wait_i,1) clocks after the disable line rises; a wait value of 0 behaves as 1.
- R4: In a read cycle (rd_nwr_i = 1) the data enable rises together with the disable line and data_o holds the register selected by address bits 2..0 from then until release, so the byte is valid before acknowledge.
- R5: In a write cycle (rd_nwr_i = 0) the data enable stays low, and data_i is stored into the register selected by address bits 2..0 on the edge at which acknowledge is asserted; a later read of that register returns it.
- R6: Once both strobes return high, disable, acknowledge enable and data enable fall on the third rising edge, and the acknowledge level returns high.
- R7: Acknowledge and disable stay asserted for as long as the strobes remain low after acknowledge.
- R8: Address bits outside 17..14 play no part in selection; bits above 17 and bits 13..3 may take any value in a taken cycle.
- R9: With the data strobe low but the address strobe high, no cycle is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Bus address |
| as_n_i | input | 1 | Address strobe, active low |
| ds_n_i | input | 1 | Data strobe, active low |
| rd_nwr_i | input | 1 | 1 for read, 0 for write |
| data_i | input | DATA_W | Write data from the bus |
| wait_i | input | WAIT_W | Clocks from taking the cycle to acknowledge |
| board_dis_o | output | 1 | Main-board disable, active high |
| dtack_n_o | output | 1 | Transfer acknowledge level, active low |
| dtack_oe_o | output | 1 | Acknowledge drive enable; acknowledge is released when low |
| data_o | output | DATA_W | Read data to the bus |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench keeps the default build: a 20-bit address, card number 9 in bits 17..14, eight registers and a 4-bit wait input. The 4-bit wait field lets it reach both the zero-wait clamp and the longest wait of 15 clocks, and the 20-bit address lets it set bits 19..18 and 13..3 freely to show that only the select field decides a match. Eight registers are few enough that the random phase revisits each one many times, so write-then-read ordering is exercised on every entry.

// File: rtl/exb_pkg.sv
package exb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_ACK  = 2'd2
  } exb_state_e;
endpackage

// File: rtl/exb_sync2.sv
module exb_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  // Strobes are active low, so the idle value after reset is all ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '1;
      stage2 <= '1;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/exb_window_dec.sv
module exb_window_dec #(
  parameter int ADDR_W   = 20,
  parameter int SEL_LSB  = 14,
  parameter int SEL_W    = 4,
  parameter int CARD_SEL = 9,
  parameter int REG_AW   = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [REG_AW-1:0] idx_o
);
  localparam int SEL_MSB = SEL_LSB + SEL_W - 1;
  localparam logic [SEL_W-1:0] SEL_VAL = SEL_W'(CARD_SEL);

  assign hit_o = (addr_i[SEL_MSB:SEL_LSB] == SEL_VAL);
  assign idx_o = addr_i[REG_AW-1:0];
endmodule

// File: rtl/exb_regfile.sv
module exb_regfile #(
  parameter int DATA_W = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // Synchronous write and registered read map onto block RAM.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/exb_responder.sv
module exb_responder #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int SEL_LSB  = 14,
  parameter int SEL_W    = 4,
  parameter int CARD_SEL = 9,
  parameter int REG_AW   = 3,
  parameter int WAIT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              as_n_i,
  input  logic              ds_n_i,
  input  logic              rd_nwr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              board_dis_o,
  output logic              dtack_n_o,
  output logic              dtack_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  import exb_pkg::*;

  localparam logic [WAIT_W-1:0] WAIT_ONE = WAIT_W'(1);

  logic [1:0]        strb_s;
  logic              strobe_on;
  logic              hit;
  logic [REG_AW-1:0] idx;

  exb_state_e        state;
  logic              dis_q;
  logic              ack_q;
  logic              doe_q;
  logic              rd_q;
  logic [REG_AW-1:0] idx_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] limit_q;

  logic              take;
  logic              fire;
  logic              we;
  logic              re;

  exb_sync2 #(.W(2)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({as_n_i, ds_n_i}),
    .q_o (strb_s)
  );

  assign strobe_on = ~strb_s[1] & ~strb_s[0];

  exb_window_dec #(
    .ADDR_W   (ADDR_W),
    .SEL_LSB  (SEL_LSB),
    .SEL_W    (SEL_W),
    .CARD_SEL (CARD_SEL),
    .REG_AW   (REG_AW)
  ) i_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  assign take = (state == ST_IDLE) && strobe_on && hit;
  assign fire = (state == ST_HOLD) && strobe_on && (cnt_q >= limit_q);
  assign we   = fire && !rd_q;
  assign re   = take && rd_nwr_i;

  exb_regfile #(
    .DATA_W (DATA_W),
    .AW     (REG_AW)
  ) i_regs (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (idx_q),
    .wdata_i (data_i),
    .re_i    (re),
    .raddr_i (idx),
    .rdata_o (data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      dis_q   <= 1'b0;
      ack_q   <= 1'b0;
      doe_q   <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      limit_q <= WAIT_ONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            state   <= ST_HOLD;
            dis_q   <= 1'b1;
            doe_q   <= rd_nwr_i;
            rd_q    <= rd_nwr_i;
            idx_q   <= idx;
            cnt_q   <= WAIT_ONE;
            limit_q <= (wait_i == '0) ? WAIT_ONE : wait_i;
          end
        end
        ST_HOLD: begin
          if (!strobe_on) begin
            state <= ST_IDLE;
            dis_q <= 1'b0;
            doe_q <= 1'b0;
          end else if (fire) begin
            state <= ST_ACK;
            ack_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + WAIT_ONE;
          end
        end
        ST_ACK: begin
          if (!strobe_on) begin
            state <= ST_IDLE;
            dis_q <= 1'b0;
            ack_q <= 1'b0;
            doe_q <= 1'b0;
          end
        end
        default: begin
          state <= ST_IDLE;
          dis_q <= 1'b0;
          ack_q <= 1'b0;
          doe_q <= 1'b0;
        end
      endcase
    end
  end

  assign board_dis_o = dis_q;
  assign dtack_oe_o  = ack_q;
  assign dtack_n_o   = ~ack_q;
  assign data_oe_o   = doe_q;
endmodule

// File: rtl/exb_responder_chk.sv
module exb_responder_chk (
  input logic clk,
  input logic rst,
  input logic as_n_i,
  input logic ds_n_i,
  input logic board_dis_o,
  input logic dtack_n_o,
  input logic dtack_oe_o,
  input logic data_oe_o
);
  // R3
  ack_needs_disable_chk: assert property (@(posedge clk) disable iff (rst)
    dtack_oe_o |-> board_dis_o);

  // R3
  ack_after_disable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dtack_oe_o) |-> $past(board_dis_o));

  // R4
  data_with_disable_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> board_dis_o);

  // R4
  data_rises_on_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe_o) |-> $rose(board_dis_o));

  // R6
  ack_level_released_chk: assert property (@(posedge clk) disable iff (rst)
    !dtack_oe_o |-> dtack_n_o);

  // R6
  release_in_three_chk: assert property (@(posedge clk) disable iff (rst)
    (board_dis_o && ds_n_i && $past(ds_n_i) && $past(ds_n_i, 2)) |=> !board_dis_o);

  // R9
  no_take_without_as_chk: assert property (@(posedge clk) disable iff (rst)
    (!board_dis_o && as_n_i && $past(as_n_i) && $past(as_n_i, 2)) |=> !board_dis_o);
endmodule

bind exb_responder exb_responder_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .as_n_i      (as_n_i),
  .ds_n_i      (ds_n_i),
  .board_dis_o (board_dis_o),
  .dtack_n_o   (dtack_n_o),
  .dtack_oe_o  (dtack_oe_o),
  .data_oe_o   (data_oe_o)
);

// File: tb/test_exb_responder.sv
module test_exb_responder;
  localparam int CARD = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] addr = '0;
  logic        as_n = 1'b1;
  logic        ds_n = 1'b1;
  logic        rd_nwr = 1'b1;
  logic [7:0]  wdata = '0;
  logic [3:0]  waitv = '0;
  logic        board_dis, dtack_n, dtack_oe, data_oe;
  logic [7:0]  rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [8];

  always #5 clk = ~clk;

  exb_responder i_exb_responder (
    .clk (clk), .rst (rst), .addr_i (addr), .as_n_i (as_n), .ds_n_i (ds_n),
    .rd_nwr_i (rd_nwr), .data_i (wdata), .wait_i (waitv),
    .board_dis_o (board_dis), .dtack_n_o (dtack_n), .dtack_oe_o (dtack_oe),
    .data_o (rdata), .data_oe_o (data_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [3:0] w);
    return (w == 0) ? 1 : int'(w);
  endfunction

  function automatic logic [19:0] mk_addr(input logic [3:0] sel, input logic [2:0] idx);
    logic [19:0] a;
    a = 20'($urandom);
    a[17:14] = sel;
    a[2:0] = idx;
    return a;
  endfunction

  task automatic hit_cycle(input logic [19:0] a, input bit rd, input logic [7:0] wd,
                           input logic [3:0] w, input int extra);
    int n;
    int lat;
    @(negedge clk);
    addr = a; rd_nwr = rd; wdata = wd; waitv = w; as_n = 1'b0; ds_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!board_dis && n < 10);
    chk(board_dis && n == 3, "R2 take delay", n, 3);
    if (!board_dis) begin
      as_n = 1'b1; ds_n = 1'b1; repeat (4) @(negedge clk);
      return;
    end
    if (rd) begin
      chk(data_oe == 1'b1, "R4 data enable at take", data_oe, 1);
      chk(rdata == model[a[2:0]], "R4 data before ack", rdata, model[a[2:0]]);
    end else begin
      chk(data_oe == 1'b0, "R5 no drive on write", data_oe, 0);
    end
    lat = 0;
    do begin @(negedge clk); lat++; end while (!dtack_oe && lat < 20);
    chk(lat == exp_lat(w), "R3 ack latency", lat, exp_lat(w));
    chk(dtack_n == 1'b0, "R3 ack level", dtack_n, 0);
    if (rd) chk(rdata == model[a[2:0]], "R4 data at ack", rdata, model[a[2:0]]);
    else model[a[2:0]] = wd;
    for (int k = 0; k < extra; k++) begin
      @(negedge clk);
      chk(dtack_oe && board_dis, "R7 held while strobed", dtack_oe, 1);
    end
    as_n = 1'b1; ds_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!board_dis && !dtack_oe && dtack_n && !data_oe, "R6 release",
        {board_dis, dtack_oe, dtack_n, data_oe}, 4'b0010);
    @(negedge clk);
  endtask

  task automatic miss_cycle(input logic [19:0] a, input bit rd, input bit as_on, input string req);
    bit seen;
    @(negedge clk);
    addr = a; rd_nwr = rd; wdata = 8'h5A; waitv = 4'd1; as_n = !as_on; ds_n = 1'b0;
    seen = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (board_dis || dtack_oe || data_oe || !dtack_n) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
    as_n = 1'b1; ds_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] other;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!board_dis && !dtack_oe && dtack_n && !data_oe, "R1 reset",
        {board_dis, dtack_oe, dtack_n, data_oe}, 4'b0010);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!board_dis && !dtack_oe && dtack_n && !data_oe, "R1 after reset",
        {board_dis, dtack_oe, dtack_n, data_oe}, 4'b0010);

    // R5 fill every register, zero wait exercises the R3 clamp
    for (int i = 0; i < 8; i++)
      hit_cycle(mk_addr(4'(CARD), 3'(i)), 1'b0, 8'(8'h30 + i * 7), 4'd0, 0);
    // R4 read back with shortest and longest waits, R8 with random outer bits
    for (int i = 0; i < 8; i++)
      hit_cycle(mk_addr(4'(CARD), 3'(i)), 1'b1, 8'h00, (i % 2 == 0) ? 4'd1 : 4'd15, 1);
    // R8 top bits set, middle bits all ones
    hit_cycle({2'b11, 4'(CARD), 11'h7FF, 3'd5}, 1'b1, 8'h00, 4'd2, 0);
    hit_cycle({2'b10, 4'(CARD), 11'h000, 3'd5}, 1'b0, 8'hC3, 4'd3, 2);
    hit_cycle({2'b01, 4'(CARD), 11'h2AA, 3'd5}, 1'b1, 8'h00, 4'd0, 3);
    // R2 neighbouring and far select values are ignored
    miss_cycle(mk_addr(4'(CARD + 1), 3'd0), 1'b1, 1'b1, "R2 miss read");
    miss_cycle(mk_addr(4'(CARD - 1), 3'd1), 1'b0, 1'b1, "R2 miss write");
    miss_cycle(mk_addr(4'd0, 3'd2), 1'b1, 1'b1, "R2 miss zero");
    // R9 data strobe alone
    miss_cycle(mk_addr(4'(CARD), 3'd3), 1'b0, 1'b0, "R9 no address strobe");
    hit_cycle(mk_addr(4'(CARD), 3'd3), 1'b1, 8'h00, 4'd1, 0);
    // R7 long hold
    hit_cycle(mk_addr(4'(CARD), 3'd6), 1'b1, 8'h00, 4'd4, 6);

    for (int t = 0; t < 120; t++) begin
      if ($urandom_range(9) < 7) begin
        hit_cycle(mk_addr(4'(CARD), 3'($urandom)), 1'($urandom), 8'($urandom),
                  4'($urandom_range(6)), $urandom_range(3));
      end else begin
        other = 4'($urandom);
        if (other == 4'(CARD)) other = other + 4'd3;
        miss_cycle(mk_addr(other, 3'($urandom)), 1'($urandom), 1'b1, "R2 random miss");
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule